// File: doc/BRIEF.md
# Selectable Bipolar Line-Code Encoder

This block turns a serial unipolar NRZ bit stream into two unipolar return-to-zero rails. One rail carries positive marks and the other carries negative marks, and circuitry outside the block merges them into a ternary line signal. One of four line codes is chosen at run time. Plain alternate mark inversion sends each one as a pulse of the opposite polarity to the previous pulse. The three zero-substitution codes replace long runs of zeros with patterns that hold deliberate polarity violations, which keeps enough pulses on the line for clock recovery.

Each input bit first passes through an eight-stage symbol delay line. When a run of zeros completes inside that window, the whole run is rewritten with the substitution pattern before its first bit leaves the line. Because of this the latency is the same in every code. A polarity stage at the end of the line assigns each pulse to a rail and registers both rails on the rising edge. The rails are then gated with the clock, so each pulse lasts only for the clock-high phase. Two output controls act on the rails. Mute blanks both rails. Force-alarm replaces the data with an endless alternating all-ones pattern.

Top module: `linecode_enc`

## Requirements
- R1: `code_sel` chooses the code as 0 = alternate mark inversion, 1 = eight-zero substitution, 2 = six-zero substitution, 3 = four-zero (parity-based) substitution. A bit presented before rising edge k shows up on the rails in the high phase that follows rising edge k+8, whatever the code.
- R2: With code 0, a zero gives no pulse on either rail, and every one gives a pulse whose polarity is the opposite of the previous pulse. The first one after reset goes on `pos_rz`.
- R3: With code 1, each run of eight zeros is sent as 0,0,0,V,B,0,V,B. A V pulse has the same polarity as the pulse before it, and a B pulse has the opposite polarity.
- R4: With code 2, each run of six zeros is sent as 0,V,B,0,V,B, using the V and B rules of R3.
- R5: With code 3, each run of four zeros is sent as B,0,0,V when the count of non-V pulses since the last V (or since reset) is even, and as 0,0,0,V when that count is odd. As a result, consecutive V pulses alternate in polarity.
- R6: An inserted B pulse advances the alternation state exactly as a data one does. A V pulse leaves the alternation state unchanged. After any substitution, the next data one therefore takes the polarity opposite to the last pulse sent.
- R7: The two rails are never high together, and both rails are low whenever `clk` is low.
- R8: When `out_mute` is high at a rising edge, both rails stay low for the cycle that follows. The encoder keeps advancing its delay line and polarity state as if the pulses had been sent. Mute takes priority over `force_ais`.
- R9: When `force_ais` is high and `out_mute` is low at a rising edge, the rails carry one pulse in that cycle in place of the delayed symbol. The pulse polarity is the opposite of the previous pulse.
- R10: While `rst_n` is low, the rails, the delay line, the zero-run count and the polarity state are all zero. The polarity state reads zero as "last pulse was negative", and the parity count starts even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; rails launch on its rising edge and return to zero when it falls |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrz_in | input | 1 | Serial unipolar NRZ data, one bit per clock |
| code_sel | input | 2 | Line-code select (see R1) |
| out_mute | input | 1 | High forces both rails low |
| force_ais | input | 1 | High sends alternating all-ones on the rails |
| pos_rz | output | 1 | Return-to-zero rail for positive pulses |
| neg_rz | output | 1 | Return-to-zero rail for negative pulses |

## Verification
Several rules are checked by assertions on every cycle. These cover the rail exclusion and the return to zero in the low phase, the blanking that follows mute, and the single alternating pulse that force-alarm produces. They also cover the reset state and the alternation of pulses once alternate mark inversion has been held long enough to flush the delay line. The substitution patterns cannot be seen from one or two cycles of the ports. This applies to the V and B polarities, the parity choice in the four-zero code, and the fixed eight-cycle latency. Only the bench's scenarios show these, by comparing each rail against a behavioural queue model on every cycle for runs of several lengths, back-to-back runs and pseudo-random data.

// File: rtl/linecode_pkg.sv
package linecode_pkg;

    typedef enum logic [1:0] {
        CODE_AMI  = 2'd0,
        CODE_Z8   = 2'd1,
        CODE_Z6   = 2'd2,
        CODE_Z4   = 2'd3
    } code_t;

    // Symbols held in the lookahead line
    typedef enum logic [2:0] {
        SYM_ZERO = 3'd0,
        SYM_MARK = 3'd1,
        SYM_VIOL = 3'd2,
        SYM_BAL  = 3'd3,
        SYM_LEAD = 3'd4   // four-zero code: becomes B or 0 at output time
    } sym_t;

    // Length of the zero run that triggers substitution (0 = never)
    function automatic int run_len(code_t c);
        case (c)
            CODE_Z8: return 8;
            CODE_Z6: return 6;
            CODE_Z4: return 4;
            default: return 0;
        endcase
    endfunction

    // Symbol at time position p (0 = earliest) of the substitution pattern
    function automatic sym_t subst_sym(code_t c, int p);
        sym_t s;
        s = SYM_ZERO;
        case (c)
            CODE_Z8: begin
                if (p == 3 || p == 6) s = SYM_VIOL;
                if (p == 4 || p == 7) s = SYM_BAL;
            end
            CODE_Z6: begin
                if (p == 1 || p == 4) s = SYM_VIOL;
                if (p == 2 || p == 5) s = SYM_BAL;
            end
            CODE_Z4: begin
                if (p == 0) s = SYM_LEAD;
                if (p == 3) s = SYM_VIOL;
            end
            default: s = SYM_ZERO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/linecode_subst.sv
module linecode_subst
    import linecode_pkg::*;
#(
    parameter int DEPTH = 8,   // must be at least the longest run (8)
    parameter int CNT_W = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  data_in,
    input  code_t code,
    output sym_t  head
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        sym_t [DEPTH-1:0] line;
        logic [CNT_W-1:0] zrun;
    } subst_st_t;

    subst_st_t st_d, st_q;
    int        n_run;

    always_comb begin
        n_run = run_len(code);
        st_d  = st_q;
        for (int i = DEPTH - 1; i > 0; i--) begin
            st_d.line[i] = st_q.line[i-1];
        end
        st_d.line[0] = data_in ? SYM_MARK : SYM_ZERO;
        if (data_in) begin
            st_d.zrun = '0;
        end else if (n_run != 0 && int'(st_q.zrun) + 1 >= n_run) begin
            st_d.zrun = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (i < n_run) begin
                    st_d.line[i] = subst_sym(code, n_run - 1 - i);
                end
            end
        end else if (st_q.zrun != CNT_MAX) begin
            st_d.zrun = st_q.zrun + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head = st_q.line[DEPTH-1];

endmodule

// File: rtl/linecode_polarity.sv
module linecode_polarity
    import linecode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_t head,
    input  logic force_ais,
    input  logic mute,
    output logic pos_q,
    output logic neg_q
);

    typedef struct packed {
        logic last_pos;  // 1: previous pulse was positive
        logic par;       // parity of alternating pulses since last V
        logic pos;
        logic neg;
    } pol_st_t;

    pol_st_t st_d, st_q;
    sym_t    sym;
    logic    alt, pulse, to_pos;

    always_comb begin
        sym    = force_ais ? SYM_MARK : head;
        alt    = (sym == SYM_MARK) || (sym == SYM_BAL) ||
                 (sym == SYM_LEAD && !st_q.par);
        pulse  = alt || (sym == SYM_VIOL);
        to_pos = alt ? ~st_q.last_pos : st_q.last_pos;

        st_d          = st_q;
        st_d.last_pos = pulse ? to_pos : st_q.last_pos;
        if (sym == SYM_VIOL) begin
            st_d.par = 1'b0;
        end else if (alt) begin
            st_d.par = ~st_q.par;
        end
        st_d.pos = pulse &  to_pos & ~mute;
        st_d.neg = pulse & ~to_pos & ~mute;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q = st_q.pos;
    assign neg_q = st_q.neg;

endmodule

// File: rtl/linecode_enc.sv
module linecode_enc
    import linecode_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nrz_in,
    input  logic [1:0] code_sel,
    input  logic       out_mute,
    input  logic       force_ais,
    output logic       pos_rz,
    output logic       neg_rz
);

    code_t code;
    sym_t  head;
    logic  pos_q, neg_q;

    assign code = code_t'(code_sel);

    linecode_subst #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_subst (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (nrz_in),
        .code    (code),
        .head    (head)
    );

    linecode_polarity u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head),
        .force_ais (force_ais),
        .mute      (out_mute),
        .pos_q     (pos_q),
        .neg_q     (neg_q)
    );

    // Return-to-zero: pulse width equals the clock high phase
    assign pos_rz = pos_q & clk;
    assign neg_rz = neg_q & clk;

endmodule

// File: rtl/linecode_enc_chk.sv
module linecode_enc_chk #(
    parameter int DEPTH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] code_sel,
    input logic       out_mute,
    input logic       force_ais,
    input logic       pos_q,
    input logic       neg_q,
    input logic       pos_rz,
    input logic       neg_rz
);

    localparam int SW = $clog2(DEPTH + 2) + 1;

    logic [SW-1:0] stab;
    logic [1:0]    code_prev;
    logic          seen, seen_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab      <= '0;
            code_prev <= '0;
            seen      <= 1'b0;
            seen_pos  <= 1'b0;
        end else begin
            code_prev <= code_sel;
            if (code_sel != code_prev) begin
                stab <= '0;
            end else if (stab != '1) begin
                stab <= stab + 1'b1;
            end
            if (out_mute || code_sel != 2'd0) begin
                seen <= 1'b0;
            end else if (pos_q || neg_q) begin
                seen     <= 1'b1;
                seen_pos <= pos_q;
            end
        end
    end

    AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_q && neg_q)) else $error("rails high together"); // R7

    AST_RZ_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_rz && !neg_rz) else $error("rail high in low phase"); // R7

    AST_MUTE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        out_mute |=> (!pos_q && !neg_q)) else $error("mute ignored"); // R8

    AST_AIS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ais && !out_mute) |=> (pos_q != neg_q)) else $error("alarm pulse missing"); // R9

    AST_AIS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ais && !out_mute && (pos_q || neg_q)) |=> (pos_q == $past(neg_q)))
        else $error("alarm polarity repeated"); // R9

    AST_AMI_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel == 2'd0 && stab >= SW'(DEPTH + 1) && seen && (pos_q || neg_q))
        |-> (pos_q != seen_pos)) else $error("mark polarity repeated"); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (!pos_q && !neg_q)) else $error("rails set in reset"); // R10

endmodule

bind linecode_enc linecode_enc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_sel  (code_sel),
    .out_mute  (out_mute),
    .force_ais (force_ais),
    .pos_q     (pos_q),
    .neg_q     (neg_q),
    .pos_rz    (pos_rz),
    .neg_rz    (neg_rz)
);

// File: tb/linecode_enc_bench.sv
`timescale 1ns/1ps
module linecode_enc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       nrz_in = 1'b0;
    logic [1:0] code_sel = 2'd0;
    logic       out_mute = 1'b0;
    logic       force_ais = 1'b0;
    logic       pos_rz, neg_rz;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // behavioural model state
    int  q[$];
    int  zrun;
    bit  m_last_pos;
    bit  m_par;
    int  m_code;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    linecode_enc u_linecode_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrz_in    (nrz_in),
        .code_sel  (code_sel),
        .out_mute  (out_mute),
        .force_ais (force_ais),
        .pos_rz    (pos_rz),
        .neg_rz    (neg_rz)
    );

    function automatic string pat_of(int c);
        case (c)
            1: return "000VB0VB";
            2: return "0VB0VB";
            3: return "H00V";
            default: return "";
        endcase
    endfunction

    // 0 zero, 1 mark, 2 V, 3 B, 4 lead
    function automatic int sym_of(byte ch);
        case (ch)
            "V": return 2;
            "B": return 3;
            "H": return 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input bit b, input bit m, input bit f,
                              output bit ep, output bit en);
        string pat;
        int    n, head;
        bit    alt, pulse, topos;
        pat = pat_of(m_code);
        n   = pat.len();
        q.push_back(b ? 1 : 0);
        if (b) zrun = 0;
        else begin
            zrun++;
            if (n > 0 && zrun == n) begin
                for (int j = 0; j < n; j++) q[q.size() - n + j] = sym_of(pat[j]);
                zrun = 0;
            end
        end
        head = 0;
        if (q.size() > 8) head = q.pop_front();
        if (f) head = 1;
        alt   = (head == 1) || (head == 3) || (head == 4 && !m_par);
        pulse = alt || (head == 2);
        topos = alt ? !m_last_pos : m_last_pos;
        if (pulse) m_last_pos = topos;
        if (head == 2) m_par = 0;
        else if (alt) m_par = !m_par;
        ep = pulse && topos && !m;
        en = pulse && !topos && !m;
    endtask

    task automatic check(input string tag, input bit ap, input bit an,
                         input bit ep, input bit en);
        n_vec++;
        if (ap !== ep || an !== en) begin
            n_bad++;
            $display("FAIL %s t=%0t pos_rz=%b neg_rz=%b expected pos=%b neg=%b",
                     tag, $time, ap, an, ep, en);
        end
    endtask

    // Called in the clock low phase; applies inputs for the next edge
    task automatic step(input bit b, input bit m, input bit f, input string tag);
        bit ep, en;
        nrz_in = b; out_mute = m; force_ais = f;
        @(posedge clk);
        model_step(b, m, f, ep, en);
        #1;
        check(tag, pos_rz, neg_rz, ep, en);
        #2;
        check("R7 low phase", pos_rz, neg_rz, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input int c);
        rst_n = 1'b0;
        code_sel = 2'(c);
        nrz_in = 0; out_mute = 0; force_ais = 0;
        q.delete(); zrun = 0; m_last_pos = 0; m_par = 0; m_code = c;
        repeat (2) begin
            @(posedge clk); #1;
            check("R10 reset", pos_rz, neg_rz, 1'b0, 1'b0);
        end
        #2;
        rst_n = 1'b1;
    endtask

    task automatic bits(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) step(s[i] == "1", 1'b0, 1'b0, tag);
    endtask

    task automatic rnd(input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // bias toward zeros so runs occur
            step(lfsr[0] & lfsr[3], 1'b0, 1'b0, tag);
        end
    endtask

    initial begin
        #1;
        do_reset(0);
        // R1 latency and R2 first mark positive
        bits("1000000000000000", "R1 latency");
        bits("10110011101000000000000000001", "R2 alternate marks");
        rnd(40, "R2 random");
        bits("000000000", "R2 flush");

        do_reset(1);
        bits("1000000001", "R3 single run");
        bits("0000000000000000110000000100000000", "R3 back-to-back runs");
        bits("11000000001", "R6 mark after substitution");
        rnd(60, "R3 random");
        bits("000000000", "R3 flush");

        do_reset(2);
        bits("00000010000001", "R4 runs");
        bits("000000000000110000011", "R4 back-to-back");
        rnd(60, "R4 random");
        bits("000000000", "R4 flush");

        do_reset(3);
        bits("000010000", "R5 even then odd");
        bits("110000110000000000000001", "R5 parity cases");
        bits("0000000000000000", "R5 repeated V alternation");
        rnd(60, "R5 random");
        bits("000000000", "R5 flush");

        do_reset(1);
        bits("1101", "R8 prefill");
        for (int i = 0; i < 12; i++) step(i % 3 != 0 ? 1'b0 : 1'b1, 1'b1, 1'b0, "R8 mute");
        bits("1011000000001", "R8 state advanced");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b1, "R9 force alarm");
        step(1'b1, 1'b1, 1'b1, "R8 mute over alarm");
        bits("1100000000", "R9 after alarm");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule